// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block owns a 32-bank on-chip scratchpad and accepts one warp-wide access at a time. The access carries one byte address per lane, an active-lane mask, a direction flag and one 32-bit write word per lane. The arbiter maps each lane to a bank and a row. It then replays the access over as many passes as the worst bank needs, one pass per clock. In every pass each bank serves exactly one location. Lanes that read the same location share that pass, and the word is broadcast to all of them.

A mode input picks the bank width. With 4-byte banks, each bank row holds one 32-bit word. With 8-byte banks, each bank row holds 64 bits split into two 32-bit halves, and lanes that touch the two halves of one row are served together. Read data comes back per lane with a lane-valid strobe. A busy flag covers the replay. A one-cycle done pulse reports the number of passes the access used.

Top module: `spad_conflict_arbiter`

## Requirements
- R1: After a synchronous reset, busy, done, every rd_valid bit and pass_count are all zero.
- R2: A request is taken when req_valid is high while busy is low. busy is high from the cycle after acceptance for exactly pass_count cycles. done pulses for one cycle as busy falls. A request presented while busy is high is ignored and leaves the scratchpad unchanged.
- R3: With req_wide low, a lane's bank is address bits [6:2] and its row is bits [10:7]. An access whose active lanes use distinct banks finishes in one pass.
- R4: pass_count equals the largest number of distinct rows that any single bank is asked for.
- R5: Lanes that read the same location are served in the same pass and all receive its word, so they add no pass.
- R6: For a read, every active lane is returned exactly once, with its rd_valid bit high in the cycle after the pass that served it. A write request never raises rd_valid.
- R7: When several active lanes write the same location in one request, the word from the highest-numbered of those lanes is stored.
- R8: With req_wide high, a lane's bank is address bits [7:3], its row is bits [11:8], and bit 2 picks the lower (0) or upper (1) 32-bit half. Lanes that touch different halves of one row share a pass, for reads and for writes.
- R9: In each pass, a bank serves the row asked for by its lowest-numbered lane that is still pending.
- R10: Lanes outside req_mask are never accessed and never return data. An empty mask gives done with pass_count zero in the cycle after acceptance, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte banks, 0 = 4-byte banks |
| req_mask | input | LANES | Active lanes |
| req_addr | input | LANES*AW | Per-lane byte address, lane l in bits [l*AW +: AW] |
| req_wdata | input | LANES*DW | Per-lane write word |
| busy | output | 1 | Replay in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| pass_count | output | PCW | Number of passes used by the last completed request |
| rd_valid | output | LANES | Per-lane read-data strobe |
| rd_data | output | LANES*DW | Per-lane read word |

## Verification
The checks assume that every lane address is word aligned and that the environment only counts a request as taken when busy is low. The bench therefore clears the two low address bits of every lane, including the pseudo-random ones, and waits for the previous completion before it raises req_valid again. The one exception is on purpose: a stray write raised while busy, whose effect is then probed through a later read. Contents written in one bank-width mode are read back only through addresses whose row and half decode the same way in the bench's model, so any aliasing between the two modes is predicted and not left to chance.

// File: rtl/spad_pkg.sv
package spad_pkg;
  localparam int SPAD_LANES = 32;
  localparam int SPAD_ROWS  = 16;
  localparam int SPAD_DW    = 32;
  localparam int SPAD_AW    = 12;

  typedef enum logic [0:0] {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/spad_pass_sched.sv
module spad_pass_sched #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int BW    = 5,
  parameter int RW    = 4
) (
  input  logic [LANES-1:0]    pending,
  input  logic [LANES*BW-1:0] lane_bank,
  input  logic [LANES*RW-1:0] lane_row,
  output logic [LANES-1:0]    served,
  output logic [BANKS-1:0]    bank_act,
  output logic [BANKS*RW-1:0] bank_row
);
  // Per bank: the lowest pending lane decides the row (loop runs downward,
  // so the last match, the lowest lane, wins).
  always_comb begin
    bank_act = '0;
    bank_row = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && lane_bank[l*BW +: BW] == BW'(b)) begin
          bank_act[b]          = 1'b1;
          bank_row[b*RW +: RW] = lane_row[l*RW +: RW];
        end
      end
    end
  end

  // A lane is served when its row matches the row chosen for its bank.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pending[l] &&
                  (lane_row[l*RW +: RW] == bank_row[lane_bank[l*BW +: BW]*RW +: RW]);
    end
  end
endmodule

// File: rtl/spad_write_merge.sv
module spad_write_merge #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int BW    = 5,
  parameter int DW    = 32
) (
  input  logic                  wr_go,
  input  logic [LANES-1:0]      served,
  input  logic [LANES*BW-1:0]   lane_bank,
  input  logic [LANES-1:0]      lane_half,
  input  logic [LANES*DW-1:0]   lane_wdata,
  output logic [BANKS*2-1:0]    bank_we,
  output logic [BANKS*2*DW-1:0] bank_wd
);
  // Ascending lane order: the highest served lane on a bank half wins.
  always_comb begin
    bank_we = '0;
    bank_wd = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int h = 0; h < 2; h++) begin
        for (int l = 0; l < LANES; l++) begin
          if (wr_go && served[l] && lane_bank[l*BW +: BW] == BW'(b) &&
              lane_half[l] == h[0]) begin
            bank_we[b*2+h]           = 1'b1;
            bank_wd[(b*2+h)*DW +: DW] = lane_wdata[l*DW +: DW];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int ROWS = 16,
  parameter int DW   = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wd_lo,
  input  logic [DW-1:0] wd_hi,
  output logic [2*DW-1:0] rd
);
  logic [DW-1:0] mem_lo [ROWS];
  logic [DW-1:0] mem_hi [ROWS];

  always_ff @(posedge clk) begin
    if (we_lo) mem_lo[row] <= wd_lo;
    if (we_hi) mem_hi[row] <= wd_hi;
    if (re)    rd <= {mem_hi[row], mem_lo[row]};
  end
endmodule

// File: rtl/spad_conflict_arbiter.sv
module spad_conflict_arbiter
  import spad_pkg::*;
#(
  parameter int LANES = SPAD_LANES,
  parameter int ROWS  = SPAD_ROWS,
  parameter int DW    = SPAD_DW,
  parameter int AW    = SPAD_AW,
  localparam int BANKS = LANES,
  localparam int BW    = $clog2(BANKS),
  localparam int RW    = $clog2(ROWS),
  localparam int PCW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [PCW-1:0]      pass_count,
  output logic [LANES-1:0]    rd_valid,
  output logic [LANES*DW-1:0] rd_data
);
  logic                wr_q;
  logic                wide_q;
  logic [LANES-1:0]    mask_q;
  logic [LANES-1:0]    pending;
  logic [PCW-1:0]      cnt;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;

  logic [LANES*BW-1:0]   lane_bank;
  logic [LANES*RW-1:0]   lane_row;
  logic [LANES-1:0]      lane_half;
  logic [LANES-1:0]      served;
  logic [BANKS-1:0]      bank_act;
  logic [BANKS*RW-1:0]   bank_row;
  logic [BANKS*2-1:0]    bank_we;
  logic [BANKS*2*DW-1:0] bank_wd;
  logic [BANKS*2*DW-1:0] bank_rd;
  logic [LANES-1:0]      left_after;
  logic                  accept;

  assign accept     = req_valid && !busy;
  assign left_after = pending & ~served;

  // Lane address decode for both bank widths.
  for (genvar l = 0; l < LANES; l++) begin : g_dec
    logic [AW-1:0] a;
    assign a = addr_q[l*AW +: AW];
    always_comb begin
      if (wide_q) begin
        lane_bank[l*BW +: BW] = a[BW+2:3];
        lane_row[l*RW +: RW]  = a[RW+BW+2:BW+3];
        lane_half[l]          = a[2];
      end else begin
        lane_bank[l*BW +: BW] = a[BW+1:2];
        lane_row[l*RW +: RW]  = a[RW+BW+1:BW+2];
        lane_half[l]          = HALF_LO;
      end
    end
  end

  spad_pass_sched #(.LANES(LANES), .BANKS(BANKS), .BW(BW), .RW(RW)) u_sched (
    .pending   (busy ? pending : '0),
    .lane_bank (lane_bank),
    .lane_row  (lane_row),
    .served    (served),
    .bank_act  (bank_act),
    .bank_row  (bank_row)
  );

  spad_write_merge #(.LANES(LANES), .BANKS(BANKS), .BW(BW), .DW(DW)) u_merge (
    .wr_go      (busy && wr_q),
    .served     (served),
    .lane_bank  (lane_bank),
    .lane_half  (lane_half),
    .lane_wdata (wdata_q),
    .bank_we    (bank_we),
    .bank_wd    (bank_wd)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spad_bank #(.ROWS(ROWS), .DW(DW)) u_bank (
      .clk   (clk),
      .re    (busy && !wr_q && bank_act[b]),
      .we_lo (bank_we[b*2]),
      .we_hi (bank_we[b*2+1]),
      .row   (bank_row[b*RW +: RW]),
      .wd_lo (bank_wd[(b*2)*DW +: DW]),
      .wd_hi (bank_wd[(b*2+1)*DW +: DW]),
      .rd    (bank_rd[b*2*DW +: 2*DW])
    );
  end

  // Read return: bank output register, steered by the captured lane decode.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [2*DW-1:0] w;
      w = bank_rd[lane_bank[l*BW +: BW]*2*DW +: 2*DW];
      rd_data[l*DW +: DW] = lane_half[l] ? w[2*DW-1:DW] : w[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      pass_count <= '0;
      rd_valid   <= '0;
      pending    <= '0;
      cnt        <= '0;
      wr_q       <= 1'b0;
      wide_q     <= 1'b0;
      mask_q     <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= (busy && !wr_q) ? served : '0;
      if (accept) begin
        wr_q    <= req_write;
        wide_q  <= req_wide;
        mask_q  <= req_mask;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        pending <= req_mask;
        cnt     <= '0;
        if (req_mask == '0) begin
          done       <= 1'b1;
          pass_count <= '0;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy) begin
        pending <= left_after;
        cnt     <= cnt + PCW'(1);
        if (left_after == '0) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          pass_count <= cnt + PCW'(1);
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic misalign;
  logic pass_clash;

  always_comb begin
    misalign = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (req_mask[l] && req_addr[l*AW +: 2] != 2'b00) misalign = 1'b1;
  end

  always_comb begin
    pass_clash = 1'b0;
    for (int l = 0; l < LANES; l++)
      for (int k = l + 1; k < LANES; k++)
        if (served[l] && served[k] &&
            lane_bank[l*BW +: BW] == lane_bank[k*BW +: BW] &&
            lane_row[l*RW +: RW] != lane_row[k*RW +: RW])
          pass_clash = 1'b1;
  end

  // R3 input assumption: accepted lanes are word aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    accept |-> !misalign);
  // R4: one row per bank in every pass
  a_r4_conflict_free: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pass_clash);
  // R2: every busy cycle retires at least one lane
  a_r2_progress: assert property (@(posedge clk) disable iff (rst)
    busy |-> (served != '0));
  // R2: completion pulse accompanies the end of replay
  a_r2_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R6: writes return nothing
  a_r6_write_silent: assert property (@(posedge clk) disable iff (rst)
    (rd_valid != '0) |-> !wr_q);
  // R10: strobes stay inside the active mask
  a_r10_valid_in_mask: assert property (@(posedge clk) disable iff (rst)
    (rd_valid & ~mask_q) == '0);
  // R4: pass count never exceeds the lane count
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass_count <= PCW'(LANES)));
endmodule

// File: tb/tb_spad_conflict_arbiter.sv
module tb_spad_conflict_arbiter;
  localparam int LANES = 32;
  localparam int BANKS = 32;
  localparam int ROWS  = 16;
  localparam int DW    = 32;
  localparam int AW    = 12;
  localparam int PCW   = 6;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic                req_write = 1'b0;
  logic                req_wide = 1'b0;
  logic [LANES-1:0]    req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic                busy;
  logic                done;
  logic [PCW-1:0]      pass_count;
  logic [LANES-1:0]    rd_valid;
  logic [LANES*DW-1:0] rd_data;

  always #2 clk = ~clk;

  spad_conflict_arbiter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_mask(req_mask), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .pass_count(pass_count),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct {
    logic [LANES-1:0]    m;
    logic [LANES*DW-1:0] d;
    string               tag;
  } beat_t;

  beat_t beat_q[$];
  int    done_q[$];
  string tag_q[$];
  logic [DW-1:0] mem_m [BANKS][ROWS][2];
  int n_chk = 0;
  int n_fail = 0;
  int bcnt = 0;
  bit finished = 0;

  function automatic int fb(logic [AW-1:0] a, bit w);
    return w ? int'(a[7:3]) : int'(a[6:2]);
  endfunction
  function automatic int fr(logic [AW-1:0] a, bit w);
    return w ? int'(a[11:8]) : int'(a[10:7]);
  endfunction
  function automatic int fh(logic [AW-1:0] a, bit w);
    return w ? int'(a[2]) : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: predicts the passes from the requirements, queues them, then drives.
  task automatic send(input string tag, input bit wr, input bit wide,
                      input logic [LANES-1:0] mask, input logic [LANES*AW-1:0] av,
                      input logic [LANES*DW-1:0] dv, input bit intrude);
    logic [LANES-1:0] pend;
    int n;
    while (beat_q.size() != 0 || done_q.size() != 0 || busy) @(negedge clk);
    pend = mask;
    n = 0;
    while (pend != '0) begin
      int brow[BANKS];
      bit bset[BANKS];
      logic [LANES-1:0] srv;
      beat_t bt;
      for (int b = 0; b < BANKS; b++) begin bset[b] = 0; brow[b] = 0; end
      for (int l = 0; l < LANES; l++) begin
        int b2;
        b2 = fb(av[l*AW +: AW], wide);
        if (pend[l] && !bset[b2]) begin
          bset[b2] = 1;
          brow[b2] = fr(av[l*AW +: AW], wide);
        end
      end
      srv = '0;
      for (int l = 0; l < LANES; l++)
        if (pend[l] && fr(av[l*AW +: AW], wide) == brow[fb(av[l*AW +: AW], wide)])
          srv[l] = 1'b1;
      if (wr) begin
        for (int l = 0; l < LANES; l++)
          if (srv[l])
            mem_m[fb(av[l*AW +: AW], wide)][fr(av[l*AW +: AW], wide)][fh(av[l*AW +: AW], wide)]
              = dv[l*DW +: DW];
      end else begin
        bt.m = srv;
        bt.d = '0;
        bt.tag = tag;
        for (int l = 0; l < LANES; l++)
          if (srv[l])
            bt.d[l*DW +: DW] =
              mem_m[fb(av[l*AW +: AW], wide)][fr(av[l*AW +: AW], wide)][fh(av[l*AW +: AW], wide)];
        beat_q.push_back(bt);
      end
      pend &= ~srv;
      n++;
    end
    done_q.push_back(n);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_wide = wide;
    req_mask = mask; req_addr = av; req_wdata = dv;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      // R2: stray write while busy, must be ignored
      req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b0; req_mask = '1;
      for (int l = 0; l < LANES; l++) begin
        req_addr[l*AW +: AW]  = AW'(l*4);
        req_wdata[l*DW +: DW] = 32'hDEAD0000 | DW'(l);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected items as the design produces results.
  initial begin
    beat_t bt;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (busy) bcnt++;
        if (rd_valid != '0) begin
          if (beat_q.size() == 0) begin
            check(0, "R6", "unexpected read beat", 64'(rd_valid), 64'(0));
          end else begin
            bit ok;
            logic [DW-1:0] ga, ge;
            bt = beat_q.pop_front();
            check(rd_valid == bt.m, bt.tag, "lane-valid mask", 64'(rd_valid), 64'(bt.m));
            ok = 1; ga = '0; ge = '0;
            for (int l = 0; l < LANES; l++)
              if (bt.m[l] && ok && rd_data[l*DW +: DW] !== bt.d[l*DW +: DW]) begin
                ok = 0; ga = rd_data[l*DW +: DW]; ge = bt.d[l*DW +: DW];
              end
            check(ok, bt.tag, "read data", 64'(ga), 64'(ge));
          end
        end
        if (done) begin
          if (done_q.size() == 0) begin
            check(0, "R2", "unexpected done", 64'(1), 64'(0));
          end else begin
            int e;
            string t;
            e = done_q.pop_front();
            t = tag_q.pop_front();
            check(int'(pass_count) == e, t, "pass count", 64'(pass_count), 64'(e));
            check(bcnt == e, "R2", "busy cycles", 64'(bcnt), 64'(e));
            check(beat_q.size() == 0, "R6", "beats left at done", 64'(beat_q.size()), 64'(0));
          end
          bcnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [LANES*AW-1:0] av;
    logic [LANES*DW-1:0] dv;
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check(busy == 0, "R1", "busy after reset", 64'(busy), 64'(0));
    check(done == 0, "R1", "done after reset", 64'(done), 64'(0));
    check(rd_valid == 0, "R1", "rd_valid after reset", 64'(rd_valid), 64'(0));
    check(pass_count == 0, "R1", "pass_count after reset", 64'(pass_count), 64'(0));

    // R8: fill every bank row with 8-byte writes, two lanes per entry
    for (int k = 0; k < 32; k++) begin
      for (int l = 0; l < LANES; l++) begin
        int e;
        e = k*16 + l/2;
        av[l*AW +: AW] = AW'(e*8 + (l%2)*4);
        dv[l*DW +: DW] = 32'hC0DE0000 ^ DW'(e*2 + l%2);
      end
      send("R8", 1, 1, '1, av, dv, 0);
    end

    // R3: stride-1 read, row 4
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(512 + l*4);
    send("R3", 0, 0, '1, av, '0, 0);
    // R6: stride-1 read, row 1
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(128 + l*4);
    send("R6", 0, 0, '1, av, '0, 0);
    // R4: stride-2 words, two rows per even bank
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(l*8);
    send("R4", 0, 0, '1, av, '0, 0);
    // R4/R5: all lanes in bank 0, 16 rows, paired lanes alias; stray write (R2)
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(l*128);
    send("R5", 0, 0, '1, av, '0, 1);
    // R2: stray write must not have changed row 0
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(l*4);
    send("R2", 0, 0, '1, av, '0, 0);
    // R5: full broadcast
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = 12'h2C4;
    send("R5", 0, 0, '1, av, '0, 0);
    // R9: lanes 0,2 on row 2 and lane 1 on row 0 of bank 5
    av = '0;
    av[0*AW +: AW] = 12'h114; av[1*AW +: AW] = 12'h014; av[2*AW +: AW] = 12'h114;
    send("R9", 0, 0, 32'h7, av, '0, 0);
    // R7: three lanes write one word; highest lane wins
    av = '0; dv = '0;
    av[3*AW +: AW] = 12'h040; dv[3*DW +: DW] = 32'h11111111;
    av[9*AW +: AW] = 12'h040; dv[9*DW +: DW] = 32'h99999999;
    av[20*AW +: AW] = 12'h040; dv[20*DW +: DW] = 32'h20202020;
    send("R7", 1, 0, 32'h0010_0208, av, dv, 0);
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = 12'h040;
    send("R7", 0, 0, 32'h0000_0001, av, '0, 0);
    // R8: halves of one entry share a pass
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(l*4);
    send("R8", 0, 1, '1, av, '0, 0);
    av = '0;
    av[0*AW +: AW] = 12'h000; av[1*AW +: AW] = 12'h100;
    send("R8", 0, 1, 32'h3, av, '0, 0);
    av = '0; dv = '0;
    av[5*AW +: AW] = 12'h408; dv[5*DW +: DW] = 32'h0A0A0A0A;
    av[6*AW +: AW] = 12'h40C; dv[6*DW +: DW] = 32'h0B0B0B0B;
    send("R8", 1, 1, 32'h60, av, dv, 0);
    send("R8", 0, 1, 32'h60, av, '0, 0);
    // R10: partial and empty masks
    for (int l = 0; l < LANES; l++) av[l*AW +: AW] = AW'(l*4);
    send("R10", 0, 0, 32'h0000_F0F0, av, '0, 0);
    send("R10", 0, 0, 32'h0, av, '0, 0);
    send("R10", 1, 0, 32'h0, av, dv, 0);
    // R4: pseudo-random mixes with forced bank conflicts
    lf = 32'hACE1_2345;
    for (int it = 0; it < 40; it++) begin
      logic [LANES-1:0] mk;
      bit w, wd;
      for (int l = 0; l < LANES; l++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        av[l*AW +: AW] = lf[AW-1:0] & 12'hF1C;
        dv[l*DW +: DW] = lf ^ 32'h5A5A_0000;
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      mk = lf;
      w  = lf[3];
      wd = lf[7];
      send("R4", w, wd, mk, av, dv, 0);
    end
    while (beat_q.size() != 0 || done_q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule